// File: doc/BRIEF.md
# Static Clock Stop and Restart Controller

This block takes a free-running oscillator and derives three clocks from it: a processor clock, a 50%-duty companion clock and a peripheral clock. It also drives an enable flag for the buffered oscillator output. The processor can halt every derived clock by driving a two-step pattern on its three status lines. An external active-high start request brings the clocks back. A restart always waits out a fixed number of oscillator cycles, counted only while the oscillator is flagged valid. This makes all outputs resume together, in phase, with no short pulses.

No data stream flows through the block, so every pin is a plain control or clock pin and there is no valid/ready handshake. All inputs are taken to be synchronous to `osc_clk`, and all outputs are registered. The processor clock runs at one third of the oscillator rate in fast mode. In slow mode it is divided down by a further fixed factor. Mode changes are applied only between processor clock cycles.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until a restart count completes, `cpu_clk`, `half_clk`, `per_clk` and `osc_en` are all low.
- R2: From the stopped or reset state, the outputs start on the edge that completes SETTLE_CYCLES (default 8192) consecutive oscillator cycles with `osc_valid` high. Any cycle with `osc_valid` low restarts the count from zero.
- R3: In fast mode `cpu_clk` has a period of 3 oscillator cycles and is high for 1 of them.
- R4: `half_clk` has a period of 3 oscillator cycles, is high for 1.5 of them, and rises together with `cpu_clk` in fast mode.
- R5: `per_clk` is `cpu_clk` divided by 2 (50% duty). It changes only on an edge where `cpu_clk` rises.
- R6: In slow mode (`slow_sel` = 1) the `cpu_clk` period is 3*SLOW_DIV oscillator cycles (default 768), and the clock is high for SLOW_DIV of them.
- R7: `slow_sel` is sampled on the last oscillator cycle of each `cpu_clk` period. A change therefore applies from the next `cpu_clk` period, and the current period finishes in the old mode.
- R8: `stat_in` is sampled at every `cpu_clk` rise; bit 2 is the stop line. A sample of 3'b111 followed by a sample of 3'b011 at the very next rise requests a stop. Any other value after 3'b111 clears the first step.
- R9: A requested stop takes effect on the first `cpu_clk` falling edge at which `per_clk` is low. From that edge, `cpu_clk`, `per_clk` and `osc_en` are low, and `half_clk` ends its current high phase normally. No high phase is shortened. With `per_clk` low at the sampling rise, the halt comes 1 oscillator cycle later; with `per_clk` high, it comes 4 cycles later.
- R10: While `start_req` is high, a stop pattern is ignored and any pending stop is cancelled. The clocks keep running.
- R11: While stopped, `start_req` high begins a restart. `cpu_clk`, `half_clk`, `per_clk` and `osc_en` all rise on the same edge, SETTLE_CYCLES + 1 oscillator cycles after `start_req` is first sampled high, provided `osc_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_valid | input | 1 | Oscillator amplitude valid flag |
| stat_in | input | 3 | Processor status lines; bit 2 doubles as stop line |
| start_req | input | 1 | Active-high start / stop-override request |
| slow_sel | input | 1 | 1 = slow mode, 0 = fast mode |
| cpu_clk | output | 1 | Processor clock, 1/3 high duty |
| half_clk | output | 1 | Oscillator / 3 clock at 50% duty |
| per_clk | output | 1 | Peripheral clock, `cpu_clk` / 2 |
| osc_en | output | 1 | Buffered oscillator output enable |

## Verification
A corrupted divider phase shows up within one processor period as a wrong rise-to-rise spacing or a wrong high count on `cpu_clk`, `half_clk` or `per_clk`. A mishandled stop detector shows up as `osc_en` falling at the wrong time: too early, too late, or while `start_req` is high. Because the halt point depends on the `per_clk` phase, it can be off by one or four oscillator cycles. A settle counter that is off by one, or that is not cleared, moves the restart edge away from exactly SETTLE_CYCLES (or SETTLE_CYCLES + 1) cycles after the trigger, so the error appears on the first output edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_RUN    = 2'd1,
    ST_HALT   = 2'd2
  } cs_state_e;

  // two-step stop pattern on the status lines (bit 2 is the stop line)
  localparam logic [2:0] STAT_ARM  = 3'b111;
  localparam logic [2:0] STAT_FIRE = 3'b011;
endpackage

// File: rtl/cs_settle_cnt.sv
module cs_settle_cnt #(
  parameter int SETTLE_CYCLES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic osc_valid,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = en && osc_valid && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || !osc_valid) cnt <= '0;
    else if (cnt == LAST)      cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R2: a cycle without a valid oscillator throws the partial count away
  a_r2_invalid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_valid |=> (cnt == '0));
endmodule

// File: rtl/cs_status_seq.sv
module cs_status_seq
  import clkstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic       sample,
  input  logic       start_req,
  input  logic [2:0] stat_in,
  output logic       stop_pend
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      stop_pend <= 1'b0;
    end else if (!running || start_req) begin
      armed     <= 1'b0;
      stop_pend <= 1'b0;
    end else if (sample) begin
      armed <= (stat_in == STAT_ARM);
      if (armed && (stat_in == STAT_FIRE)) stop_pend <= 1'b1;
    end
  end

  // R8: a stop request only follows an armed first step
  a_r8_fire_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pend) |-> $past(armed));
  // R10: start request cancels any pending stop
  a_r10_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !stop_pend);
endmodule

// File: rtl/cs_divider.sv
module cs_divider #(
  parameter int SLOW_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic active,
  input  logic halt_now,
  input  logic slow_sel,
  output logic cpu_q,
  output logic half_clk,
  output logic per_q,
  output logic cycle_end,
  output logic fall_pt
);
  localparam int SW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SLOW_DIV - 1);

  logic [1:0]    ph, ph_n, h3, h3_n;
  logic [SW-1:0] sub, sub_n;
  logic          mode_q, s_wrap, half_pos, half_neg;

  always_comb begin
    s_wrap    = !mode_q || (sub == S_LAST);
    cycle_end = active && (ph == 2'd2) && s_wrap;
    fall_pt   = active && (ph == 2'd0) && s_wrap;
    ph_n      = s_wrap ? ((ph == 2'd2) ? 2'd0 : ph + 2'd1) : ph;
    sub_n     = s_wrap ? '0 : sub + 1'b1;
    h3_n      = (h3 == 2'd2) ? 2'd0 : h3 + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; sub <= '0; h3 <= '0; mode_q <= 1'b0;
      cpu_q <= 1'b0; half_pos <= 1'b0; per_q <= 1'b0;
    end else if (launch) begin
      ph <= '0; sub <= '0; h3 <= '0; mode_q <= slow_sel;
      cpu_q <= 1'b1; half_pos <= 1'b1; per_q <= 1'b1;
    end else if (!active || halt_now) begin
      cpu_q <= 1'b0; half_pos <= 1'b0; per_q <= 1'b0;
    end else begin
      ph       <= ph_n;
      sub      <= sub_n;
      h3       <= h3_n;
      cpu_q    <= (ph_n == 2'd0);
      half_pos <= (h3_n == 2'd0);
      if (cycle_end) begin
        per_q  <= ~per_q;
        mode_q <= slow_sel;
      end
    end
  end

  // half-cycle extension gives the 50% duty companion clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_neg <= 1'b0;
    else        half_neg <= half_pos;
  end

  assign half_clk = half_pos | half_neg;

  // R3: in fast mode the processor clock is high for exactly one cycle
  a_r3_fast_one_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_q && !mode_q) |=> !cpu_q);
  // R5: peripheral clock only moves where the processor clock rises
  a_r5_per_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> $rose(cpu_q));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8192,
  parameter int SLOW_DIV      = 256
) (
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       osc_valid,
  input  logic [2:0] stat_in,
  input  logic       start_req,
  input  logic       slow_sel,
  output logic       cpu_clk,
  output logic       half_clk,
  output logic       per_clk,
  output logic       osc_en
);
  cs_state_e st, st_n;
  logic settle_done, launch, halt_now, stop_pend, cycle_end, fall_pt;
  logic osc_en_q;

  cs_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(osc_clk), .rst_n(rst_n), .en(st == ST_SETTLE),
    .osc_valid(osc_valid), .done(settle_done)
  );

  cs_status_seq u_seq (
    .clk(osc_clk), .rst_n(rst_n), .running(st == ST_RUN),
    .sample(cycle_end), .start_req(start_req), .stat_in(stat_in),
    .stop_pend(stop_pend)
  );

  cs_divider #(.SLOW_DIV(SLOW_DIV)) u_div (
    .clk(osc_clk), .rst_n(rst_n), .launch(launch), .active(st == ST_RUN),
    .halt_now(halt_now), .slow_sel(slow_sel), .cpu_q(cpu_clk),
    .half_clk(half_clk), .per_q(per_clk), .cycle_end(cycle_end),
    .fall_pt(fall_pt)
  );

  assign launch   = (st == ST_SETTLE) && settle_done;
  assign halt_now = (st == ST_RUN) && stop_pend && fall_pt && !per_clk && !start_req;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_SETTLE: if (launch)    st_n = ST_RUN;
      ST_RUN:    if (halt_now)  st_n = ST_HALT;
      ST_HALT:   if (start_req) st_n = ST_SETTLE;
      default:                  st_n = ST_SETTLE;
    endcase
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_SETTLE;
      osc_en_q <= 1'b0;
    end else begin
      st       <= st_n;
      osc_en_q <= (st_n == ST_RUN);
    end
  end

  assign osc_en = osc_en_q;

  // R1: nothing toggles outside the run state
  a_r1_idle_low: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st != ST_RUN) |-> (!cpu_clk && !per_clk && !osc_en));
  // R9: the halt lands on a processor-clock fall with the peripheral clock low
  a_r9_halt_on_fall: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == ST_HALT && $past(st) == ST_RUN) |-> ($past(cpu_clk) && !$past(per_clk)));
  // R10: an active start request keeps the clocks running
  a_r10_start_holds_run: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (st == ST_RUN && start_req) |=> (st == ST_RUN));
  // R11: all outputs resume on one edge
  a_r11_resume_together: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(osc_en) |-> (cpu_clk && per_clk && half_clk && $past(osc_valid)));
endmodule

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
  localparam int N  = 8192;
  localparam int SD = 256;
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0, rst_n = 1'b0, osc_valid = 1'b0, start_req = 1'b0, slow_sel = 1'b0;
  logic [2:0] stat_in = 3'b000;
  logic cpu_clk, half_clk, per_clk, osc_en;
  logic cpu_last = 1'b0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  clk_stop_ctrl #(.SETTLE_CYCLES(N), .SLOW_DIV(SD)) dut_i (
    .osc_clk(clk), .rst_n(rst_n), .osc_valid(osc_valid), .stat_in(stat_in),
    .start_req(start_req), .slow_sel(slow_sel), .cpu_clk(cpu_clk),
    .half_clk(half_clk), .per_clk(per_clk), .osc_en(osc_en)
  );

  function automatic int exp_len(bit slow);
    return slow ? 3 * SD : 3;
  endfunction

  function automatic bit exp_stop(logic [2:0] prev, logic [2:0] cur, bit st);
    return !st && (prev == 3'b111) && (cur == 3'b011);
  endfunction

  function automatic int exp_halt_delay(bit per_at_rise);
    return per_at_rise ? 4 : 1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    cpu_last = cpu_clk;
    @(posedge clk);
    #5;
  endtask

  task automatic wait_rise(input int lim, output int n, output int nh);
    bit fin;
    fin = 1'b0; n = 0; nh = 0;
    while (!fin) begin
      tick();
      n++;
      if (cpu_clk && !cpu_last) fin = 1'b1;
      else begin
        if (cpu_clk) nh++;
        if (n >= lim) begin n = -1; fin = 1'b1; end
      end
    end
  endtask

  task automatic send(input logic [2:0] v, input bit st, output int n);
    int nh;
    stat_in = v;
    start_req = st;
    wait_rise(12, n, nh);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, nh, h, ch, pc, off, k, hi;
    logic pl, per_r;
    logic [2:0] prev, v;
    bit s, halted;
    void'($urandom(32'd2024));

    // R1: reset state
    repeat (3) tick();
    chk("R1 outputs during reset", {cpu_clk, half_clk, per_clk, osc_en}, 0);
    rst_n = 1'b1;
    repeat (20) tick();
    chk("R1 outputs idle without valid oscillator", {cpu_clk, half_clk, per_clk, osc_en}, 0);

    // R2: partial count then a dropout, then the full count
    osc_valid = 1'b1;
    hi = 0;
    repeat (3000) begin tick(); if (cpu_clk || osc_en) hi++; end
    chk("R2 no start before full count", hi, 0);
    osc_valid = 1'b0;
    repeat (5) tick();
    osc_valid = 1'b1;
    wait_rise(N + 10, n, nh);
    chk("R2 settle length after dropout", n, N);
    chk("R11 outputs start together", {cpu_clk, half_clk, per_clk, osc_en}, 4'hF);

    // R4: half-cycle sampled duty
    h = 0;
    for (int i = 0; i < 6; i++) begin h += int'(half_clk); #10; end
    chk("R4 half_clk high half-samples per period", h, 3);
    chk("R3 cpu_clk high again after 3 cycles", cpu_clk, 1);

    // R3 / R5: fast stream
    ch = 0; pc = 0; off = 0; pl = per_clk;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (cpu_clk) ch++;
      if (per_clk) pc++;
      if ((per_clk != pl) && !(cpu_clk && !cpu_last)) off++;
      pl = per_clk;
    end
    chk("R3 cpu_clk highs in 24 cycles", ch, 8);
    chk("R5 per_clk highs in 24 cycles", pc, 12);
    chk("R5 per_clk moves only on cpu rise", off, 0);

    // R6 / R7: mode changes apply at the period boundary
    slow_sel = 1'b1;
    wait_rise(20, n, nh);
    chk("R7 current fast period completes", n, exp_len(1'b0));
    wait_rise(3 * SD + 20, n, nh);
    chk("R6 slow period", n, exp_len(1'b1));
    chk("R6 slow high length", nh + 1, SD);
    slow_sel = 1'b0;
    wait_rise(3 * SD + 20, n, nh);
    chk("R7 current slow period completes", n, exp_len(1'b1));
    wait_rise(20, n, nh);
    chk("R7 fast again", n, exp_len(1'b0));

    // R8: broken pattern does not stop
    send(3'b111, 1'b0, n); chk("R8 running after arm", n, 3);
    send(3'b101, 1'b0, n); chk("R8 running after mismatch", n, 3);
    send(3'b011, 1'b0, n); chk("R8 running after unarmed fire", n, 3);
    repeat (10) tick();
    chk("R8 mismatch clears first step", osc_en, 1);

    // R10: start high masks a full stop pattern
    wait_rise(20, n, nh);
    send(3'b111, 1'b1, n);
    send(3'b011, 1'b1, n); chk("R10 running with start high", n, 3);
    send(3'b000, 1'b0, n);
    repeat (10) tick();
    chk("R10 stop ignored under start", osc_en, 1);

    // R9: directed stop with halt timing
    wait_rise(20, n, nh);
    send(3'b111, 1'b0, n);
    send(3'b011, 1'b0, n);
    per_r = per_clk;
    k = 0;
    while (osc_en && k < 12) begin tick(); k++; end
    chk("R9 halt delay from sampling rise", k, exp_halt_delay(per_r));
    chk("R9 cpu/per low at halt", {cpu_clk, per_clk}, 0);
    hi = 0;
    repeat (2) tick();
    repeat (50) begin tick(); if (cpu_clk || half_clk || per_clk || osc_en) hi++; end
    chk("R9 outputs stay low while stopped", hi, 0);

    // R11: restart
    stat_in = 3'b000;
    start_req = 1'b1;
    wait_rise(N + 10, n, nh);
    chk("R11 restart latency", n, N + 1);
    chk("R11 outputs resume together", {cpu_clk, half_clk, per_clk, osc_en}, 4'hF);
    start_req = 1'b0;

    // random status traffic
    for (int r = 0; r < 3; r++) begin
      prev = 3'b000; halted = 1'b0;
      for (int i = 0; i < 60 && !halted; i++) begin
        case ($urandom % 4)
          0:       v = 3'b111;
          1:       v = 3'b011;
          default: v = 3'($urandom % 8);
        endcase
        s = (($urandom % 6) == 0);
        send(v, s, n);
        if (exp_stop(prev, v, s)) begin
          start_req = 1'b0;
          k = 0;
          while (osc_en && k < 8) begin tick(); k++; end
          chk("R8 random stop pattern halts", osc_en, 0);
          stat_in = 3'b000;
          start_req = 1'b1;
          wait_rise(N + 10, n, nh);
          chk("R11 random restart latency", n, N + 1);
          start_req = 1'b0;
          halted = 1'b1;
        end else begin
          chk("R8 random non-stop keeps running", n, 3);
        end
        prev = s ? 3'b000 : v;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule